// File: doc/BRIEF.md
# Interrupt Priority Tracker

This block keeps, for a single processor core, the set of interrupt vectors that have been requested and the set that the core has taken but not yet finished. Each request is a strobe carrying an 8-bit vector. A request sets one bit in a 256-bit request array. The block offers the highest requested vector to the core only when that vector's priority class is above the current processor priority. The priority class of a vector is its upper nibble. When the core acknowledges, the vector moves from the request array to the in-service array.

The processor priority is derived from two things: the highest vector now in service and a task priority that software writes. An end-of-interrupt strobe carries no vector. It retires the highest vector in service, which is the one setting the processor priority. A vector that has been handed to the core stays blocked until its end-of-interrupt arrives, even if the core goes idle first. New requests for that vector collect in the request array and wait.

Top module: `irq_prio_track`

## Requirements
- R1: A synchronous active-low reset clears every request and in-service bit and sets the task priority to 0. After reset, the processor priority reads 0x00 and interrupt-pending is low.
- R2: A request strobe for vector v (16 to 255) sets bit v of the request array. Bit v lies in 32-bit word v/32 at position v%32. A second request for a vector whose bit is already set merges into that bit, so one acknowledge consumes both.
- R3: Requests for vectors 0 to 15 are reserved and ignored. They set no bit and cause no delivery.
- R4: The processor priority equals the task priority when the task priority's upper nibble is at least the upper nibble of the highest in-service vector. Otherwise it equals that vector's upper nibble with a zero low nibble. With no vector in service, the in-service class counts as 0.
- R5: Interrupt-pending is high exactly when some request bit is set and the upper nibble of the highest requested vector is strictly greater than the upper nibble of the processor priority. The offered vector is that highest requested vector.
- R6: An acknowledge while interrupt-pending is high clears the offered vector's request bit and sets its in-service bit on the same clock edge. The processor priority reflects the change from the next cycle onward.
- R7: An end-of-interrupt clears only the highest set in-service bit.
- R8: An end-of-interrupt while no in-service bit is set changes nothing.
- R9: A vector whose in-service bit is set is never offered, even if it is requested again. After its end-of-interrupt, a repeated request for it is offered.
- R10: A task priority write takes effect on the next cycle. A task priority of 0 masks no vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_vec | input | 8 | Vector of the request |
| tpr_we | input | 1 | Task priority write strobe |
| tpr_wdata | input | 8 | Task priority value to write |
| eoi | input | 1 | End-of-interrupt strobe |
| core_ack | input | 1 | Core takes the offered vector |
| irq_pending | output | 1 | A vector is offered to the core |
| irq_vector | output | 8 | Highest requested vector |
| ppr | output | 8 | Processor priority |
| irr_bits | output | 256 | Request array, bit index equals vector |
| isr_bits | output | 256 | In-service array, bit index equals vector |

## Verification
The bench nests two in-service vectors and retires them with operand-less end-of-interrupts. A design that cleared the lowest or a fixed vector would report the wrong processor priority and would offer a waiting vector too early. It re-requests a vector that is already in service and checks that the vector stays blocked until its end-of-interrupt. A tracker that forgot blocking would offer it at once. It raises the task priority to the class of a waiting request to test the strict comparison, where a greater-or-equal test would deliver wrongly. It also sends a request for a reserved vector, an end-of-interrupt with nothing in service, and a duplicate request, and checks the bit words and the pending line after each.

// File: rtl/irq_prio_track.sv
module irq_prio_track #(
  parameter int RSVD_VECS = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic [7:0]   req_vec,
  input  logic         tpr_we,
  input  logic [7:0]   tpr_wdata,
  input  logic         eoi,
  input  logic         core_ack,
  output logic         irq_pending,
  output logic [7:0]   irq_vector,
  output logic [7:0]   ppr,
  output logic [255:0] irr_bits,
  output logic [255:0] isr_bits
);

  localparam int NVEC = 256;

  logic [NVEC-1:0] irr_q, isr_q;
  logic [7:0]      tpr_q;

  function automatic logic [8:0] top_set(input logic [NVEC-1:0] b);
    logic [8:0] r;
    r = '0;
    for (int i = 0; i < NVEC; i++)
      if (b[i]) r = {1'b1, 8'(i)};
    return r;
  endfunction

  logic [8:0] irr_top, isr_top;
  assign irr_top = top_set(irr_q);
  assign isr_top = top_set(isr_q);

  logic [3:0] isr_cls;
  assign isr_cls = isr_top[8] ? isr_top[7:4] : 4'h0;

  assign ppr         = (tpr_q[7:4] >= isr_cls) ? tpr_q : {isr_cls, 4'h0};
  assign irq_vector  = irr_top[7:0];
  assign irq_pending = irr_top[8] && (irr_top[7:4] > ppr[7:4]);

  logic            take, req_ok;
  logic [NVEC-1:0] take_mask, eoi_mask, req_mask;

  assign take      = core_ack && irq_pending;
  assign req_ok    = req_valid && (int'(req_vec) >= RSVD_VECS);
  assign take_mask = take ? (NVEC'(1) << irq_vector) : '0;
  assign eoi_mask  = (eoi && isr_top[8]) ? (NVEC'(1) << isr_top[7:0]) : '0;
  assign req_mask  = req_ok ? (NVEC'(1) << req_vec) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q <= '0;
      isr_q <= '0;
      tpr_q <= '0;
    end else begin
      irr_q <= (irr_q & ~take_mask) | req_mask;
      isr_q <= (isr_q & ~eoi_mask) | take_mask;
      if (tpr_we) tpr_q <= tpr_wdata;
    end
  end

  assign irr_bits = irr_q;
  assign isr_bits = isr_q;

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (irr_bits == '0 && isr_bits == '0 && ppr == 8'h00));

  p_reserved_never_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irr_bits[15:0] == 16'h0);

  p_ack_moves_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (core_ack && irq_pending && !(req_valid && req_vec == irq_vector))
      |=> (isr_bits[$past(irq_vector)] && !irr_bits[$past(irq_vector)]));

  p_eoi_empty_noop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && isr_bits == '0 && !(core_ack && irq_pending)) |=> isr_bits == '0);

  p_inservice_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> !isr_bits[irq_vector]);

  p_ppr_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tpr_we) |-> ppr[7:4] >= $past(tpr_wdata[7:4]));

endmodule

// File: tb/irq_prio_track_bench.sv
module irq_prio_track_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n, req_valid, tpr_we, eoi, core_ack;
  logic [7:0]   req_vec, tpr_wdata;
  logic         irq_pending;
  logic [7:0]   irq_vector, ppr;
  logic [255:0] irr_bits, isr_bits;

  irq_prio_track u_irq_prio_track (
    .clk, .rst_n, .req_valid, .req_vec, .tpr_we, .tpr_wdata, .eoi, .core_ack,
    .irq_pending, .irq_vector, .ppr, .irr_bits, .isr_bits
  );

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] op, input logic [7:0] d);
    @(negedge clk);
    req_valid = (op == 3'd1); req_vec   = d;
    tpr_we    = (op == 3'd2); tpr_wdata = d;
    core_ack  = (op == 3'd3);
    eoi       = (op == 3'd4);
    @(posedge clk); #2;
    req_valid = 0; tpr_we = 0; core_ack = 0; eoi = 0;
  endtask

  // {op, data, pending, vector, ppr}; op 0 idle, 1 request, 2 tpr write, 3 ack, 4 eoi
  localparam logic [27:0] TBL [15] = '{
    {3'd1, 8'h31, 1'b1, 8'h31, 8'h00},
    {3'd1, 8'h52, 1'b1, 8'h52, 8'h00},
    {3'd3, 8'h00, 1'b0, 8'h31, 8'h50},
    {3'd1, 8'h5A, 1'b0, 8'h5A, 8'h50},
    {3'd1, 8'h61, 1'b1, 8'h61, 8'h50},
    {3'd3, 8'h00, 1'b0, 8'h5A, 8'h60},
    {3'd4, 8'h00, 1'b0, 8'h5A, 8'h50},
    {3'd4, 8'h00, 1'b1, 8'h5A, 8'h00},
    {3'd2, 8'h70, 1'b0, 8'h5A, 8'h70},
    {3'd2, 8'h4F, 1'b1, 8'h5A, 8'h4F},
    {3'd3, 8'h00, 1'b0, 8'h31, 8'h50},
    {3'd4, 8'h00, 1'b0, 8'h31, 8'h4F},
    {3'd2, 8'h00, 1'b1, 8'h31, 8'h00},
    {3'd3, 8'h00, 1'b0, 8'h31, 8'h30},
    {3'd4, 8'h00, 1'b0, 8'h31, 8'h00}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_vec = 0; tpr_we = 0; tpr_wdata = 0; eoi = 0; core_ack = 0;
    repeat (3) @(posedge clk); #2;
    rst_n = 1;
    chk(!irq_pending && ppr == 8'h00, "R1 reset", {23'd0, irq_pending, ppr}, 32'h0);
    chk(irr_bits == '0 && isr_bits == '0, "R1 arrays", irr_bits[31:0] | isr_bits[31:0], 32'h0);

    // R4 R5 R6 R7 R10 table walk
    for (int i = 0; i < 15; i++) begin
      step(TBL[i][27:25], TBL[i][24:17]);
      chk(irq_pending == TBL[i][16], $sformatf("R5 pending step %0d", i), 32'(irq_pending), 32'(TBL[i][16]));
      chk(ppr == TBL[i][7:0], $sformatf("R4 ppr step %0d", i), 32'(ppr), 32'(TBL[i][7:0]));
      if (TBL[i][16])
        chk(irq_vector == TBL[i][15:8], $sformatf("R5 vector step %0d", i), 32'(irq_vector), 32'(TBL[i][15:8]));
    end

    // R3 reserved vector
    step(3'd1, 8'h0F);
    chk(irr_bits == '0 && !irq_pending, "R3 reserved", irr_bits[31:0], 32'h0);

    // R2 word placement and R6 in-service word
    step(3'd1, 8'hF3);
    chk(irr_bits[255:224] == 32'h0008_0000, "R2 request word", irr_bits[255:224], 32'h0008_0000);
    step(3'd3, 8'h00);
    chk(isr_bits[255:224] == 32'h0008_0000 && irr_bits == '0, "R6 in-service word", isr_bits[255:224], 32'h0008_0000);
    chk(ppr == 8'hF0, "R4 ppr F0", 32'(ppr), 32'hF0);

    // R9 blocked until eoi despite re-request and idle cycles
    step(3'd1, 8'hF3);
    step(3'd0, 8'h00);
    step(3'd0, 8'h00);
    chk(!irq_pending && irr_bits[243], "R9 blocked", 32'(irq_pending), 32'h0);
    step(3'd4, 8'h00);
    chk(irq_pending && irq_vector == 8'hF3 && ppr == 8'h00, "R9 reoffer", 32'(irq_vector), 32'hF3);
    step(3'd3, 8'h00);
    step(3'd4, 8'h00);

    // R2 duplicate request merges
    step(3'd1, 8'h80);
    step(3'd1, 8'h80);
    step(3'd3, 8'h00);
    chk(irr_bits == '0 && !irq_pending, "R2 duplicate", irr_bits[159:128], 32'h0);
    step(3'd4, 8'h00);
    chk(isr_bits == '0 && ppr == 8'h00, "R7 single eoi", isr_bits[159:128], 32'h0);

    // R8 eoi with nothing in service; R5 strict compare at equal class
    step(3'd1, 8'h40);
    step(3'd2, 8'h40);
    chk(!irq_pending, "R5 equal class", 32'(irq_pending), 32'h0);
    step(3'd4, 8'h00);
    chk(isr_bits == '0 && irr_bits[64] && ppr == 8'h40, "R8 empty eoi", 32'(ppr), 32'h40);
    step(3'd2, 8'h00);
    chk(irq_pending && irq_vector == 8'h40, "R10 tpr zero", 32'(irq_vector), 32'h40);

    // R1 reset mid-run
    step(3'd3, 8'h00);
    step(3'd2, 8'h20);
    @(negedge clk); rst_n = 0;
    @(posedge clk); #2; rst_n = 1;
    chk(irr_bits == '0 && isr_bits == '0 && ppr == 8'h00 && !irq_pending, "R1 reset mid-run", 32'(ppr), 32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule